// File: doc/BRIEF.md
# Microcontroller Power-Mode Sequencer

This block is the clock-gating and power-mode controller of a small microcontroller core. One sleep strobe from the core chooses the next mode. If the held idle-enable bit is clear, the strobe enters full Sleep: every device clock stops and the selected oscillator is switched off. If the bit is set, the strobe enters Idle: only the CPU clock stops, and the peripherals keep running from the source chosen by a 2-bit select field.

An interrupt or a watchdog timeout brings the device back to a Run mode. The wake path depends on where the device is coming from:
- From Idle, the CPU waits a fixed ready interval before it runs again.
- From Sleep with the primary oscillator selected, the device stays unclocked during a start-up count. When the PLL is configured, a PLL lock count follows.
- With two-speed start-up, the internal RC clocks the device early while the primary source is still starting.

A synchronous reset event, like the asynchronous reset, restores the default configuration and runs the start-up sequence again. The delay lengths are parameters given in reference clock cycles. The oscillators, the PLL, the watchdog and the interrupt logic lie outside this block and appear only as strobes and ready levels.

Top module: `pm_seq`

## Requirements
- R1: After reset the idle-enable bit reads 0 and the select field reads 2'b00. The CPU and peripheral clocks are off, the primary oscillator is enabled, and all three status flags read 0 unless two-speed start-up is on. Run is reached OST_CYCLES edges after reset release while pri_rdy_i is high, and stat_pri_o then reads 1.
- R2: A sleep strobe in Run with idle-enable 0 enters Sleep. In Sleep the CPU clock, the peripheral clock, the primary oscillator, the PLL and all status flags are 0.
- R3: A sleep strobe in Run with idle-enable 1 enters Idle. On the next cycle the CPU clock is 0, the peripheral clock is 1, and the status flags are unchanged. The oscillator enables follow the select field, which is encoded as 2'b00 primary, 2'b01 secondary and 2'b1x internal RC.
- R4: wdt_en_i keeps rc_osc_en_o high in every mode, and sec_en_i keeps sec_osc_en_o high in every mode.
- R5: In Sleep and Idle only an interrupt, a watchdog timeout or a reset event causes a wake; a further sleep strobe there has no effect. In Run, interrupt and watchdog strobes have no effect.
- R6: On wake from Sleep with the primary source selected, the clocks stay off while OST_CYCLES cycles with pri_rdy_i high are counted. Cycles with pri_rdy_i low do not count. With pri_rdy_i held high, the CPU clock rises OST_CYCLES+1 edges after the edge that samples the wake.
- R7: When pll_cfg_i is set, a further PLL_CYCLES cycles with pll_lock_i high are counted after the start-up count. The PLL enable is high during this count and during the Run that follows.
- R8: With two_speed_i set, the CPU and peripheral clocks run during the start-up count, stat_rc_o is 1 and stat_pri_o is 0.
- R9: stat_pri_o rises only when the primary source is clocking the CPU in Run, that is, only after the full start-up (and lock) count.
- R10: Wake events (interrupt, watchdog) never change the idle-enable bit or the select field. Only a configuration write or a reset changes them.
- R11: On wake from Idle, the CPU clock rises IDLE_RDY_CYCLES+1 edges after the edge that samples the wake. Run then uses the selected source, and the status flag of that source is set.
- R12: A wake from Sleep with a non-primary source selected reaches Run one edge after it is sampled, with the status flag of that source set.
- R13: wake_rst_i restores the default configuration, clears the status flags and restarts the start-up count. Run follows OST_CYCLES+1 edges after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Sleep instruction strobe |
| cfg_we_i | input | 1 | Write strobe for idle-enable and select |
| cfg_idle_en_i | input | 1 | Idle-enable value to write |
| cfg_sel_i | input | 2 | Clock-source select value to write |
| wake_irq_i | input | 1 | Interrupt wake event |
| wake_wdt_i | input | 1 | Watchdog timeout wake event |
| wake_rst_i | input | 1 | Synchronous reset event |
| pll_cfg_i | input | 1 | Primary source runs through the PLL |
| two_speed_i | input | 1 | Clock from internal RC during start-up |
| wdt_en_i | input | 1 | Watchdog enabled, keeps internal RC on |
| sec_en_i | input | 1 | Secondary oscillator kept enabled |
| pri_rdy_i | input | 1 | Primary oscillator is oscillating |
| pll_lock_i | input | 1 | PLL lock indication |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| sec_osc_en_o | output | 1 | Secondary oscillator enable |
| rc_osc_en_o | output | 1 | Internal RC oscillator enable |
| stat_pri_o | output | 1 | Start-up complete: primary clocks the device |
| stat_sec_o | output | 1 | Secondary source clocks the device |
| stat_rc_o | output | 1 | Internal RC clocks the device |
| idle_en_o | output | 1 | Current idle-enable bit |
| sel_o | output | 2 | Current clock-source select |

## Verification
The hardest situation to reach is the start-up count held part-way by a primary oscillator that drops its ready level. The bench makes its behavioural ready signal follow the oscillator enable, gated by a bench switch. It closes the switch before the wake and reopens it five cycles later, so the stall can be seen in the exact wake latency. The two-speed case, in which the clocks run while stat_pri_o is still low, is reached in a similar way. The PLL lock phase is reached by tying the lock to the PLL enable, with pll_cfg_i set before the sleep.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;
  typedef enum logic [2:0] {
    ST_OST, ST_PLL, ST_RUN, ST_IDLE, ST_IWAKE, ST_SLEEP
  } pm_state_e;

  typedef enum logic [1:0] {SRC_PRI = 2'd0, SRC_SEC = 2'd1, SRC_RC = 2'd2} src_e;

  localparam int unsigned NUM_SRC = 3;

  function automatic src_e sel_to_src(input logic [1:0] sel);
    if (sel == 2'b00) return SRC_PRI;
    if (sel == 2'b01) return SRC_SEC;
    return SRC_RC;
  endfunction
endpackage

// File: rtl/pm_seq_cfg.sv
module pm_seq_cfg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       we_i,
  input  logic       idle_en_i,
  input  logic [1:0] sel_i,
  output logic       idle_en_o,
  output logic [1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_en_o <= 1'b0;
      sel_o     <= 2'b00;
    end else if (soft_rst_i) begin
      idle_en_o <= 1'b0;
      sel_o     <= 2'b00;
    end else if (we_i) begin
      idle_en_o <= idle_en_i;
      sel_o     <= sel_i;
    end
  end
endmodule

// File: rtl/pm_seq_cnt.sv
module pm_seq_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pm_seq_fsm.sv
module pm_seq_fsm
  import pm_seq_pkg::*;
#(
  parameter int unsigned OST_CYCLES      = 1024,
  parameter int unsigned PLL_CYCLES      = 8000,
  parameter int unsigned IDLE_RDY_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       idle_en_i,
  input  logic [1:0] sel_i,
  input  logic       wake_irq_i,
  input  logic       wake_wdt_i,
  input  logic       wake_rst_i,
  input  logic       pll_cfg_i,
  input  logic       pri_rdy_i,
  input  logic       pll_lock_i,
  output pm_state_e  state_o,
  output logic       run_entry_o,
  output logic       sleep_entry_o
);
  localparam int unsigned MAX_A = (OST_CYCLES > PLL_CYCLES) ? OST_CYCLES : PLL_CYCLES;
  localparam int unsigned MAX_C = (MAX_A > IDLE_RDY_CYCLES) ? MAX_A : IDLE_RDY_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  pm_state_e state_q, state_d;
  logic [CNT_W-1:0] limit;
  logic cnt_en, cnt_done, cnt_clr, wake_ev;

  assign wake_ev = wake_irq_i | wake_wdt_i;

  always_comb begin
    limit  = CNT_W'(OST_CYCLES);
    cnt_en = 1'b0;
    unique case (state_q)
      ST_OST:   begin limit = CNT_W'(OST_CYCLES);      cnt_en = pri_rdy_i;  end
      ST_PLL:   begin limit = CNT_W'(PLL_CYCLES);      cnt_en = pll_lock_i; end
      ST_IWAKE: begin limit = CNT_W'(IDLE_RDY_CYCLES); cnt_en = 1'b1;       end
      default:  ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (wake_rst_i) begin
      state_d = ST_OST;
    end else begin
      unique case (state_q)
        ST_OST:   if (cnt_done) state_d = pll_cfg_i ? ST_PLL : ST_RUN;
        ST_PLL:   if (cnt_done) state_d = ST_RUN;
        ST_RUN:   if (sleep_req_i) state_d = idle_en_i ? ST_IDLE : ST_SLEEP;
        ST_IDLE:  if (wake_ev) state_d = ST_IWAKE;
        ST_IWAKE: if (cnt_done) state_d = ST_RUN;
        ST_SLEEP: if (wake_ev) state_d = (sel_to_src(sel_i) == SRC_PRI) ? ST_OST : ST_RUN;
        default:  state_d = ST_OST;
      endcase
    end
  end

  assign cnt_clr = wake_rst_i | (state_d != state_q);

  pm_seq_cnt #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .en_i    (cnt_en),
    .limit_i (limit),
    .done_o  (cnt_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OST;
    else         state_q <= state_d;
  end

  assign state_o       = state_q;
  assign run_entry_o   = !wake_rst_i && (state_d == ST_RUN) && (state_q != ST_RUN);
  assign sleep_entry_o = !wake_rst_i && (state_d == ST_SLEEP) && (state_q != ST_SLEEP);
endmodule

// File: rtl/pm_seq_out.sv
module pm_seq_out
  import pm_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pm_state_e  state_i,
  input  logic       run_entry_i,
  input  logic       sleep_entry_i,
  input  logic       wake_rst_i,
  input  logic [1:0] sel_i,
  input  logic       pll_cfg_i,
  input  logic       two_speed_i,
  input  logic       wdt_en_i,
  input  logic       sec_en_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       pri_osc_en_o,
  output logic       pll_en_o,
  output logic       sec_osc_en_o,
  output logic       rc_osc_en_o,
  output logic [NUM_SRC-1:0] stat_o
);
  src_e act_q, sel_src, cur_src;
  logic [NUM_SRC-1:0] stat_q, src_hot;
  logic in_start, in_idle, in_run, active, early;

  assign sel_src  = sel_to_src(sel_i);
  assign in_start = (state_i == ST_OST) || (state_i == ST_PLL);
  assign in_idle  = (state_i == ST_IDLE) || (state_i == ST_IWAKE);
  assign in_run   = (state_i == ST_RUN);
  assign active   = in_run || in_idle;
  assign early    = in_start && two_speed_i;
  // Run keeps the source latched at entry; Idle follows the select field
  assign cur_src  = in_run ? act_q : sel_src;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hot
    assign src_hot[i] = (sel_src == src_e'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      act_q  <= SRC_PRI;
    end else if (wake_rst_i) begin
      stat_q <= '0;
      act_q  <= SRC_PRI;
    end else if (run_entry_i) begin
      stat_q <= src_hot;
      act_q  <= sel_src;
    end else if (sleep_entry_i) begin
      stat_q <= '0;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
    if (i == int'(SRC_RC)) begin : g_rc
      assign stat_o[i] = in_start ? two_speed_i : stat_q[i];
    end else begin : g_other
      assign stat_o[i] = in_start ? 1'b0 : stat_q[i];
    end
  end

  assign cpu_clk_en_o = in_run || early;
  assign per_clk_en_o = in_run || in_idle || early;
  assign pri_osc_en_o = in_start || (active && cur_src == SRC_PRI);
  assign pll_en_o     = pll_cfg_i && ((state_i == ST_PLL) || (active && cur_src == SRC_PRI));
  assign sec_osc_en_o = sec_en_i || (active && cur_src == SRC_SEC);
  assign rc_osc_en_o  = wdt_en_i || (active && cur_src == SRC_RC) || early;
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_seq_pkg::*;
#(
  parameter int unsigned OST_CYCLES      = 1024,
  parameter int unsigned PLL_CYCLES      = 8000,
  parameter int unsigned IDLE_RDY_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       cfg_we_i,
  input  logic       cfg_idle_en_i,
  input  logic [1:0] cfg_sel_i,
  input  logic       wake_irq_i,
  input  logic       wake_wdt_i,
  input  logic       wake_rst_i,
  input  logic       pll_cfg_i,
  input  logic       two_speed_i,
  input  logic       wdt_en_i,
  input  logic       sec_en_i,
  input  logic       pri_rdy_i,
  input  logic       pll_lock_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       pri_osc_en_o,
  output logic       pll_en_o,
  output logic       sec_osc_en_o,
  output logic       rc_osc_en_o,
  output logic       stat_pri_o,
  output logic       stat_sec_o,
  output logic       stat_rc_o,
  output logic       idle_en_o,
  output logic [1:0] sel_o
);
  pm_state_e state;
  logic run_entry, sleep_entry, run_st, sleep_st;
  logic [NUM_SRC-1:0] stat;

  pm_seq_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (wake_rst_i),
    .we_i       (cfg_we_i),
    .idle_en_i  (cfg_idle_en_i),
    .sel_i      (cfg_sel_i),
    .idle_en_o  (idle_en_o),
    .sel_o      (sel_o)
  );

  pm_seq_fsm #(
    .OST_CYCLES      (OST_CYCLES),
    .PLL_CYCLES      (PLL_CYCLES),
    .IDLE_RDY_CYCLES (IDLE_RDY_CYCLES)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sleep_req_i   (sleep_req_i),
    .idle_en_i     (idle_en_o),
    .sel_i         (sel_o),
    .wake_irq_i    (wake_irq_i),
    .wake_wdt_i    (wake_wdt_i),
    .wake_rst_i    (wake_rst_i),
    .pll_cfg_i     (pll_cfg_i),
    .pri_rdy_i     (pri_rdy_i),
    .pll_lock_i    (pll_lock_i),
    .state_o       (state),
    .run_entry_o   (run_entry),
    .sleep_entry_o (sleep_entry)
  );

  pm_seq_out u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .run_entry_i   (run_entry),
    .sleep_entry_i (sleep_entry),
    .wake_rst_i    (wake_rst_i),
    .sel_i         (sel_o),
    .pll_cfg_i     (pll_cfg_i),
    .two_speed_i   (two_speed_i),
    .wdt_en_i      (wdt_en_i),
    .sec_en_i      (sec_en_i),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .per_clk_en_o  (per_clk_en_o),
    .pri_osc_en_o  (pri_osc_en_o),
    .pll_en_o      (pll_en_o),
    .sec_osc_en_o  (sec_osc_en_o),
    .rc_osc_en_o   (rc_osc_en_o),
    .stat_o        (stat)
  );

  assign stat_pri_o = stat[SRC_PRI];
  assign stat_sec_o = stat[SRC_SEC];
  assign stat_rc_o  = stat[SRC_RC];
  assign run_st     = (state == ST_RUN);
  assign sleep_st   = (state == ST_SLEEP);
endmodule

// File: rtl/pm_seq_chk.sv
module pm_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic       cfg_we_i,
  input logic       wake_rst_i,
  input logic       wdt_en_i,
  input logic       sec_en_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       pri_osc_en_o,
  input logic       pll_en_o,
  input logic       sec_osc_en_o,
  input logic       rc_osc_en_o,
  input logic       stat_pri_o,
  input logic       stat_sec_o,
  input logic       stat_rc_o,
  input logic       idle_en_o,
  input logic [1:0] sel_o,
  input logic       run_st,
  input logic       sleep_st
);
  a_r2_sleep_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_st |-> (!cpu_clk_en_o && !per_clk_en_o && !stat_pri_o && !stat_sec_o && !stat_rc_o));

  a_r2_sleep_osc_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_st |-> (!pri_osc_en_o && !pll_en_o));

  a_r3_idle_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_st && sleep_req_i && idle_en_o && !wake_rst_i) |=>
      (!cpu_clk_en_o && per_clk_en_o && $stable({stat_pri_o, stat_sec_o, stat_rc_o})));

  a_r4_keepalive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_en_i |-> rc_osc_en_o) and (sec_en_i |-> sec_osc_en_o));

  a_r5_run_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_st && !sleep_req_i && !wake_rst_i) |=> run_st);

  a_r9_pri_flag_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_pri_o) |-> (pri_osc_en_o && cpu_clk_en_o && run_st));

  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !wake_rst_i) |=> $stable({idle_en_o, sel_o}));
endmodule

bind pm_seq pm_seq_chk u_chk (.*);

// File: tb/pm_seq_bench.sv
module pm_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OST = 8;
  localparam int PLLC = 5;
  localparam int IRDY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, cfg_we = 0, cfg_idle_en = 0;
  logic [1:0] cfg_sel = 2'b00;
  logic wake_irq = 0, wake_wdt = 0, wake_rst = 0;
  logic pll_cfg = 0, two_speed = 0, wdt_en = 0, sec_en = 0;
  logic rdy_allow = 1, lock_allow = 1;
  logic pri_rdy, pll_lock;
  logic cpu_en, per_en, pri_en, pll_en, sec_en_o, rc_en, st_pri, st_sec, st_rc, idle_en;
  logic [1:0] sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pri_rdy  = pri_en && rdy_allow;
  assign pll_lock = pll_en && lock_allow;

  pm_seq #(.OST_CYCLES(OST), .PLL_CYCLES(PLLC), .IDLE_RDY_CYCLES(IRDY)) u_pm_seq (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .cfg_we_i(cfg_we),
    .cfg_idle_en_i(cfg_idle_en), .cfg_sel_i(cfg_sel), .wake_irq_i(wake_irq),
    .wake_wdt_i(wake_wdt), .wake_rst_i(wake_rst), .pll_cfg_i(pll_cfg),
    .two_speed_i(two_speed), .wdt_en_i(wdt_en), .sec_en_i(sec_en),
    .pri_rdy_i(pri_rdy), .pll_lock_i(pll_lock), .cpu_clk_en_o(cpu_en),
    .per_clk_en_o(per_en), .pri_osc_en_o(pri_en), .pll_en_o(pll_en),
    .sec_osc_en_o(sec_en_o), .rc_osc_en_o(rc_en), .stat_pri_o(st_pri),
    .stat_sec_o(st_sec), .stat_rc_o(st_rc), .idle_en_o(idle_en), .sel_o(sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic ie, input logic [1:0] s);
    cfg_idle_en = ie; cfg_sel = s; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask

  // pulse a wake strobe, then count edges until the CPU clock runs
  task automatic wake_and_time(input bit use_wdt, output int n);
    if (use_wdt) wake_wdt = 1; else wake_irq = 1;
    @(negedge clk); wake_irq = 0; wake_wdt = 0;
    n = 1;
    while (!cpu_en && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (2) @(negedge clk);
    chk("R1 idle_en default", idle_en, 0);
    chk("R1 sel default", sel, 0);
    chk("R1 cpu off in reset start", cpu_en, 0);
    chk("R1 pri osc on", pri_en, 1);
    chk("R1 status clear", {st_pri, st_sec, st_rc}, 0);
    rst_n = 1;
    begin
      int n = 0;
      while (!cpu_en && n < 200) begin @(negedge clk); n++; end
      chk("R1 start-up length", n, OST);
    end
    chk("R1 stat_pri after start-up", st_pri, 1);
  endtask

  task automatic t_run_ignore();
    wake_irq = 1; @(negedge clk); wake_irq = 0;
    wake_wdt = 1; @(negedge clk); wake_wdt = 0;
    @(negedge clk);
    chk("R5 cpu still on after run wakes", cpu_en, 1);
    chk("R5 status unchanged", {st_pri, st_sec, st_rc}, 3'b100);
  endtask

  task automatic t_sleep_primary();
    int n;
    pulse_sleep();
    chk("R2 cpu off", cpu_en, 0);
    chk("R2 per off", per_en, 0);
    chk("R2 pri osc off", pri_en, 0);
    chk("R2 status cleared", {st_pri, st_sec, st_rc}, 0);
    chk("R4 rc off without wdt", rc_en, 0);
    wdt_en = 1; sec_en = 1; #1;
    chk("R4 rc kept by wdt", rc_en, 1);
    chk("R4 sec kept", sec_en_o, 1);
    wdt_en = 0; sec_en = 0;
    pulse_sleep(); repeat (3) @(negedge clk);
    chk("R5 sleep strobe in sleep ignored", {cpu_en, per_en}, 0);
    wake_and_time(0, n);
    chk("R6 sleep wake latency", n, OST + 1);
    chk("R9 stat_pri after wake", st_pri, 1);
    chk("R10 idle_en unchanged", idle_en, 0);
    chk("R10 sel unchanged", sel, 0);
  endtask

  task automatic t_rdy_stall();
    int n;
    pulse_sleep();
    rdy_allow = 0;
    wake_irq = 1; @(negedge clk); wake_irq = 0; n = 1;
    repeat (5) begin @(negedge clk); n++; end
    chk("R6 clocks held while not ready", cpu_en, 0);
    chk("R9 stat_pri low during start-up", st_pri, 0);
    rdy_allow = 1;
    while (!cpu_en && n < 200) begin @(negedge clk); n++; end
    chk("R6 stalled wake latency", n, OST + 1 + 5);
  endtask

  task automatic t_pll();
    int n;
    pll_cfg = 1;
    pulse_sleep();
    chk("R2 pll off in sleep", pll_en, 0);
    wake_and_time(1, n);
    chk("R7 pll wake latency", n, OST + PLLC + 1);
    chk("R7 pll enabled in run", pll_en, 1);
    chk("R9 stat_pri after lock", st_pri, 1);
    pll_cfg = 0;
  endtask

  task automatic t_two_speed();
    int n;
    two_speed = 1;
    pulse_sleep();
    wake_irq = 1; @(negedge clk); wake_irq = 0; n = 1;
    chk("R8 cpu early", cpu_en, 1);
    chk("R8 per early", per_en, 1);
    chk("R8 status rc only", {st_pri, st_sec, st_rc}, 3'b001);
    chk("R8 rc osc on", rc_en, 1);
    while (!st_pri && n < 200) begin @(negedge clk); n++; end
    chk("R9 stat_pri rise time", n, OST + 1);
    two_speed = 0;
  endtask

  task automatic t_idle();
    int n;
    cfg_write(1'b1, 2'b10);
    pulse_sleep();
    chk("R3 cpu off in idle", cpu_en, 0);
    chk("R3 per on in idle", per_en, 1);
    chk("R3 status unchanged", {st_pri, st_sec, st_rc}, 3'b100);
    chk("R3 rc osc follows select", rc_en, 1);
    chk("R3 pri osc off for rc select", pri_en, 0);
    pulse_sleep(); @(negedge clk);
    chk("R5 sleep strobe in idle ignored", cpu_en, 0);
    wake_and_time(0, n);
    chk("R11 idle wake latency", n, IRDY + 1);
    chk("R11 rc status after idle wake", {st_pri, st_sec, st_rc}, 3'b001);
    chk("R10 idle_en kept", idle_en, 1);
    chk("R10 sel kept", sel, 2);
  endtask

  task automatic t_sleep_rc();
    int n;
    cfg_write(1'b0, 2'b01);
    sec_en = 1;
    pulse_sleep();
    chk("R2 sleep from rc run", {cpu_en, per_en}, 0);
    wake_and_time(1, n);
    chk("R12 secondary wake latency", n, 1);
    chk("R12 sec status", {st_pri, st_sec, st_rc}, 3'b010);
    sec_en = 0;
  endtask

  task automatic t_wake_rst();
    int n;
    cfg_write(1'b1, 2'b11);
    wake_rst = 1; @(negedge clk); wake_rst = 0; n = 1;
    chk("R13 idle_en restored", idle_en, 0);
    chk("R13 sel restored", sel, 0);
    chk("R13 cpu off", cpu_en, 0);
    chk("R13 status cleared", {st_pri, st_sec, st_rc}, 0);
    while (!cpu_en && n < 200) begin @(negedge clk); n++; end
    chk("R13 restart latency", n, OST + 1);
    chk("R13 stat_pri after restart", st_pri, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_run_ignore();
    t_sleep_primary();
    t_rdy_stall();
    t_pll();
    t_two_speed();
    t_idle();
    t_sleep_rc();
    t_wake_rst();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule